// File: doc/BRIEF.md
# EEPROM Write Guard and Status Controller

This block sits behind the serial command decoder of a small byte-wide EEPROM. It holds the status byte and decides whether a programming request may go ahead. The decoder hands it one-cycle command strobes: enable, disable, status write with the new protection level, and data commit with a page address. It also sees the chip-select line and the hardware write-protect pin. The block keeps the write-enable latch and the two-bit protection level. It also tracks whether a programming cycle is running.

A data commit or status write is accepted while chip select is low. It is held as pending and starts only when chip select is released. If the write-protect pin drops before that release, the pending request is cancelled. Once the cycle starts, a timer of `BUSY_CYCLES` system clocks stands in for the self-timed programming time. During that time the status byte reads as all ones, and every command is ignored. When the timer ends, the write-enable latch clears itself. A status write applies its new protection level at that same moment. A data write gives a single commit pulse with the page address for the array controller. A data write into the protected region is refused at once: it never goes busy and leaves the latch as it was.

Top module: `eeprom_guard`

## Requirements
- R1: After reset the status byte is 0x00, busy and write permit are low and no commit pulse appears.
- R2: When not busy the status byte is {4'b0000, level[1:0], latch, 1'b0}: bit 0 is the busy flag, bit 1 the write-enable latch, bits 3:2 the protection level and bits 7:4 zero. Whenever busy is high the status byte reads 0xFF.
- R3: `wr_permit` is high exactly when the latch is set, `wp_n` is high and the block is not busy. A data commit or status write arriving while `wr_permit` is low is dropped.
- R4: An enable strobe with chip select low sets the latch only if `wp_n` is high.
- R5: A disable strobe with chip select low clears the latch whatever the level of `wp_n`.
- R6: The latch is cleared when any programming cycle ends.
- R7: A status write loads `stat_bp` as the new protection level when its cycle ends. The status byte keeps showing 0xFF for the whole cycle.
- R8: For an address width A, level 01 protects addresses whose two top bits are 11 (0x180-0x1FF for A=9). Level 10 protects addresses whose top bit is 1 (0x100-0x1FF). Level 11 protects every address, and level 00 protects none. A commit to a protected address is rejected: busy stays low and the latch keeps its value.
- R9: An accepted request starts busy on the first clock at which `cs_n` is seen high after being low. Busy then stays high for exactly `BUSY_CYCLES` clocks. A data write also raises `commit_pulse` for one clock, with `commit_addr_o` holding the page address.
- R10: `wp_n` low while a request is pending, before chip-select release, cancels it. `wp_n` low during a running cycle has no effect on that cycle.
- R11: Enable, disable, status-write and commit strobes are ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip-select state, low while selected |
| wp_n | input | 1 | Hardware write protect, low inhibits programming |
| en_set | input | 1 | Strobe: set write-enable latch |
| en_clr | input | 1 | Strobe: clear write-enable latch |
| stat_wr | input | 1 | Strobe: status write |
| stat_bp | input | 2 | New protection level carried by the status write |
| commit_req | input | 1 | Strobe: data write to a page |
| commit_addr | input | ADDR_W | Page start address of the data write |
| status | output | 8 | Status byte for reads |
| wr_permit | output | 1 | A programming request would be accepted now |
| commit_pulse | output | 1 | One-clock start of an accepted data write |
| commit_addr_o | output | ADDR_W | Address of the started data write |
| busy | output | 1 | Programming cycle running |

## Verification
Two pairs of events can fall into the same cycle. The first is a drop of `wp_n` against a request that is already pending or already running. The bench drops the pin between the accepted strobe and the chip-select release, and again after busy has started. It then judges the result by whether busy, the commit count and the latch bit moved. The second pair is a new enable strobe against the end-of-cycle latch clear. The bench issues the strobe during busy and expects the latch to read clear once the cycle ends.

// File: rtl/eeprom_guard.sv
module eeprom_guard #(
  parameter int ADDR_W      = 9,
  parameter int BUSY_CYCLES = 50000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wp_n,
  input  logic              en_set,
  input  logic              en_clr,
  input  logic              stat_wr,
  input  logic [1:0]        stat_bp,
  input  logic              commit_req,
  input  logic [ADDR_W-1:0] commit_addr,
  output logic [7:0]        status,
  output logic              wr_permit,
  output logic              commit_pulse,
  output logic [ADDR_W-1:0] commit_addr_o,
  output logic              busy
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);

  logic              wel, cs_q, pend_data, pend_stat, stat_cycle, prot;
  logic [1:0]        level, level_nxt;
  logic [ADDR_W-1:0] pend_addr;
  logic [CW-1:0]     cnt;

  wire sel       = ~cs_n;
  wire cs_rise   = cs_n & ~cs_q;
  wire take_data = sel & commit_req & wr_permit & ~prot & ~pend_stat;
  wire take_stat = sel & stat_wr & wr_permit & ~pend_data;

  always_comb begin
    case (level)
      2'b00:   prot = 1'b0;
      2'b01:   prot = &commit_addr[ADDR_W-1 -: 2];
      2'b10:   prot = commit_addr[ADDR_W-1];
      default: prot = 1'b1;
    endcase
  end

  assign wr_permit = wel & wp_n & ~busy;
  assign status    = busy ? 8'hFF : {4'b0000, level, wel, 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel           <= 1'b0;
      cs_q          <= 1'b1;
      pend_data     <= 1'b0;
      pend_stat     <= 1'b0;
      stat_cycle    <= 1'b0;
      level         <= 2'b00;
      level_nxt     <= 2'b00;
      pend_addr     <= '0;
      cnt           <= '0;
      busy          <= 1'b0;
      commit_pulse  <= 1'b0;
      commit_addr_o <= '0;
    end else begin
      cs_q         <= cs_n;
      commit_pulse <= 1'b0;
      if (busy) begin
        if (cnt == '0) begin
          busy       <= 1'b0;
          wel        <= 1'b0;
          stat_cycle <= 1'b0;
          if (stat_cycle) level <= level_nxt;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else begin
        if (sel && en_clr)              wel <= 1'b0;
        else if (sel && en_set && wp_n) wel <= 1'b1;

        if (!wp_n || cs_rise) begin
          pend_data <= 1'b0;
          pend_stat <= 1'b0;
        end else begin
          if (take_data) begin
            pend_data <= 1'b1;
            pend_addr <= commit_addr;
          end
          if (take_stat) begin
            pend_stat <= 1'b1;
            level_nxt <= stat_bp;
          end
        end

        if (cs_rise && wp_n && (pend_data || pend_stat)) begin
          busy       <= 1'b1;
          cnt        <= CW'(BUSY_CYCLES - 1);
          stat_cycle <= pend_stat;
          if (pend_data) begin
            commit_pulse  <= 1'b1;
            commit_addr_o <= pend_addr;
          end
        end
      end
    end
  end
endmodule

// File: rtl/eeprom_guard_chk.sv
module eeprom_guard_chk #(
  parameter int BUSY_CYCLES = 50000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       wp_n,
  input logic [7:0] status,
  input logic       wr_permit,
  input logic       commit_pulse,
  input logic       busy
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);
  logic [CW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= '0;
    else        run <= busy ? CW'(run + 1'b1) : '0;
  end

  p_all_ones_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> status == 8'hFF);

  p_idle_layout_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (status[7:4] == 4'b0000) && !status[0]);

  p_permit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_permit |-> wp_n && !busy && status[1]);

  p_latch_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy) && $rose(status[1])) |-> $past(wp_n));

  p_end_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !status[1]);

  p_start_on_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_n) && !$past(cs_n, 2));

  p_commit_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    commit_pulse |-> busy);

  p_commit_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    commit_pulse |=> !commit_pulse);

  p_busy_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> int'(run) < BUSY_CYCLES);
endmodule

bind eeprom_guard eeprom_guard_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n), .status(status),
  .wr_permit(wr_permit), .commit_pulse(commit_pulse), .busy(busy)
);

// File: tb/eeprom_guard_tb_top.sv
`timescale 1ns/1ps
module eeprom_guard_tb_top;
  localparam int AW = 9;
  localparam int B  = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, wp_n = 1'b1, en_set = 1'b0, en_clr = 1'b0, stat_wr = 1'b0, commit_req = 1'b0;
  logic [1:0]    stat_bp = 2'b00;
  logic [AW-1:0] commit_addr = '0;
  logic [7:0]    status;
  logic          wr_permit, commit_pulse, busy;
  logic [AW-1:0] commit_addr_o;

  always #4 clk = ~clk;

  eeprom_guard #(.ADDR_W(AW), .BUSY_CYCLES(B)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n), .en_set(en_set), .en_clr(en_clr),
    .stat_wr(stat_wr), .stat_bp(stat_bp), .commit_req(commit_req), .commit_addr(commit_addr),
    .status(status), .wr_permit(wr_permit), .commit_pulse(commit_pulse),
    .commit_addr_o(commit_addr_o), .busy(busy));

  typedef struct {
    logic [7:0]    st;
    logic          bsy;
    logic          perm;
    int            n;
    logic [AW-1:0] addr;
    string         tag;
  } item_t;

  item_t         exp_q[$];
  event          smp;
  int            compared = 0, mismatched = 0, cycles = 0, ncommit = 0, exp_n = 0;
  logic [AW-1:0] last_addr = '0, exp_addr = '0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst_n && commit_pulse) begin
      ncommit   <= ncommit + 1;
      last_addr <= commit_addr_o;
    end
  end

  always @(negedge clk) if (cycles >= 100000) begin
    mismatched++;
    $display("FAIL R9 watchdog: actual hung run, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial forever begin
    @(smp);
    while (exp_q.size() > 0) begin
      item_t e;
      e = exp_q.pop_front();
      compared++;
      if (status !== e.st || busy !== e.bsy || wr_permit !== e.perm ||
          ncommit != e.n || last_addr !== e.addr) begin
        mismatched++;
        $display("FAIL %s: actual st=%h busy=%b permit=%b commits=%0d addr=%h expected st=%h busy=%b permit=%b commits=%0d addr=%h",
                 e.tag, status, busy, wr_permit, ncommit, last_addr, e.st, e.bsy, e.perm, e.n, e.addr);
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(logic [7:0] st, logic bsy, logic perm, string tag);
    item_t e;
    e.st = st; e.bsy = bsy; e.perm = perm; e.n = exp_n; e.addr = exp_addr; e.tag = tag;
    exp_q.push_back(e);
    ->smp;
    #1;
  endtask

  task automatic do_en_set();
    cyc(1); cs_n = 1'b0; en_set = 1'b1; cyc(1); en_set = 1'b0; cs_n = 1'b1; cyc(1);
  endtask

  task automatic do_en_clr();
    cyc(1); cs_n = 1'b0; en_clr = 1'b1; cyc(1); en_clr = 1'b0; cs_n = 1'b1; cyc(1);
  endtask

  task automatic do_stat(logic [1:0] bp);
    cyc(1); cs_n = 1'b0; stat_wr = 1'b1; stat_bp = bp; cyc(1); stat_wr = 1'b0; cs_n = 1'b1; cyc(1);
  endtask

  task automatic do_commit(logic [AW-1:0] a);
    cyc(1); cs_n = 1'b0; commit_req = 1'b1; commit_addr = a; cyc(1); commit_req = 1'b0; cs_n = 1'b1; cyc(1);
  endtask

  initial begin
    cyc(3); rst_n = 1'b1; cyc(1);
    chk(8'h00, 0, 0, "R1 reset state");

    wp_n = 1'b0; do_en_set(); chk(8'h00, 0, 0, "R4 enable blocked by wp_n low");
    wp_n = 1'b1; do_en_set(); chk(8'h02, 0, 1, "R4 enable with wp_n high");
    wp_n = 1'b0; do_en_clr(); chk(8'h00, 0, 0, "R5 disable with wp_n low");
    wp_n = 1'b1;

    do_commit(9'h005); chk(8'h00, 0, 0, "R3 commit without latch dropped");

    do_en_set(); do_stat(2'b01);
    chk(8'hFF, 1, 0, "R2 status all ones while busy");
    cyc(B - 1); chk(8'hFF, 1, 0, "R7 still busy at last cycle");
    cyc(1); chk(8'h04, 0, 0, "R6 R7 level 01 applied, latch cleared");

    do_en_set(); do_commit(9'h180); chk(8'h06, 0, 1, "R8 level 01 rejects 0x180");
    do_commit(9'h17F); chk(8'hFF, 1, 0, "R9 accepted write goes busy");
    cyc(B); exp_n = 1; exp_addr = 9'h17F;
    chk(8'h04, 0, 0, "R9 commit pulse and address 0x17F");

    do_en_set();
    cyc(1); cs_n = 1'b0; commit_req = 1'b1; commit_addr = 9'h010; cyc(1);
    commit_req = 1'b0; wp_n = 1'b0; cyc(1); wp_n = 1'b1; cs_n = 1'b1; cyc(2);
    chk(8'h06, 0, 1, "R10 wp_n low before release cancels");

    do_commit(9'h010); wp_n = 1'b0; cyc(B); wp_n = 1'b1;
    exp_n = 2; exp_addr = 9'h010;
    chk(8'h04, 0, 0, "R10 wp_n low during cycle has no effect");

    do_en_set(); do_commit(9'h020); do_en_set(); cyc(B);
    exp_n = 3; exp_addr = 9'h020;
    chk(8'h04, 0, 0, "R11 enable during busy ignored");

    do_en_set(); wp_n = 1'b0; do_stat(2'b11); wp_n = 1'b1;
    chk(8'h06, 0, 1, "R3 status write with wp_n low dropped");

    do_stat(2'b10); cyc(B); chk(8'h08, 0, 0, "R7 level 10 applied");
    do_en_set(); do_commit(9'h100); chk(8'h0A, 0, 1, "R8 level 10 rejects 0x100");
    do_commit(9'h0FF); cyc(B); exp_n = 4; exp_addr = 9'h0FF;
    chk(8'h08, 0, 0, "R8 level 10 accepts 0x0FF");

    do_en_set(); do_stat(2'b11); cyc(B); chk(8'h0C, 0, 0, "R7 level 11 applied");
    do_en_set(); do_commit(9'h000); chk(8'h0E, 0, 1, "R8 level 11 rejects 0x000");
    do_en_clr(); chk(8'h0C, 0, 0, "R5 disable with wp_n high");

    cyc(2);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule